// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Engine

This block sends out a chain of memory buffers, one byte at a time, as a byte stream. Each buffer is described by a four-word descriptor in memory. The engine starts when it gets a one-cycle `kick` pulse that carries a descriptor address and a context address. It reads the descriptor and streams the bytes from the buffer start pointer up to, but not including, the end pointer. It then writes the descriptor back to memory. After that it either follows the next pointer or, if the descriptor is the last one, marks the context descriptor as disabled and parks in its end-of-list state.

All memory traffic goes through one master port. The port carries word reads and writes with a valid/ready handshake and allows one read in flight at a time. Long buffers are cut into chunks, and the descriptor is fetched again before every chunk. Two flags shape the output:
- A packet-end flag in the descriptor marks the final byte of that descriptor as the last byte of a packet.
- A 16-bit metadata tag is presented once at the start of each packet.

An interrupt flag in the descriptor produces a one-cycle completion pulse for the register block. That block also sees the current descriptor address and byte position at all times.

Top module: `chain_tx_dma`

## Requirements
- R1: After reset, and after reset is applied in the middle of a transfer, `busy`, `eol_flag`, `out_valid`, `mem_req_valid`, `meta_valid` and `done_irq` are all 0.
- R2: A descriptor at address D is four 32-bit words: the next pointer at D+0, the buffer start at D+4, the flags at D+8 and the end pointer at D+12. The words are read in that order. In the flags, bit 0 is end-of-list, bit 3 is packet-end, bit 4 is interrupt, and bits 31:16 are the metadata.
- R3: The bytes at addresses start through end-1 leave on `out_data`, one per `out_valid`&&`out_ready` cycle, in address order. The byte at address A is bits 8*(A mod 4)+7:8*(A mod 4) of the memory word at A with its two low bits cleared.
- R4: Each chunk is min(end − position, CHUNK_BYTES) bytes. When a chunk does not reach the end pointer, the descriptor is read again before the next chunk.
- R5: `out_last` is 1 only on the final byte of a descriptor, and only when its packet-end bit is set.
- R6: `meta_valid` pulses for one cycle with flags bits 31:16 on `meta_data`. It pulses after the first descriptor fetched following a kick, and after the first fetch that follows the completion of a packet-end descriptor. It never pulses on any other fetch.
- R7: `done_irq` pulses for one cycle when a descriptor with its interrupt bit set completes.
- R8: Every completed descriptor is written back as four word writes to D+0..D+12, carrying the values that were read.
- R9: When the end-of-list bit is clear, the next pointer becomes the descriptor address and the position restarts at the new buffer start.
- R10: When the end-of-list bit is set, the word at context+4 is read, bit 15 of it is set, and the word is written back. `eol_flag` then rises and `busy` falls.
- R11: A descriptor whose position already equals its end pointer pushes no byte but is still written back and followed.
- R12: A kick while busy is ignored. While `eol_flag` is set, the engine makes no memory request and sends no output until the next kick, and that kick clears `eol_flag`.
- R13: `cur_desc_addr` and `cur_buf_pos` show the current descriptor address and byte position. When the chain ends they hold the last descriptor's address and end pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kick | input | 1 | One-cycle start pulse |
| kick_desc_addr | input | 32 | First descriptor address, taken on kick |
| kick_ctx_addr | input | 32 | Context descriptor address, taken on kick |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Word byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream sink ready |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Last byte of packet |
| meta_valid | output | 1 | Metadata pulse |
| meta_data | output | 16 | Packet metadata |
| done_irq | output | 1 | Descriptor-completion interrupt pulse |
| eol_flag | output | 1 | End-of-list state |
| busy | output | 1 | Engine active |
| cur_desc_addr | output | 32 | Current descriptor address |
| cur_buf_pos | output | 32 | Current byte position |

## Verification
The assertions assume the following about the environment:
- The memory returns exactly one `mem_rsp_valid` for each accepted read, never before the acceptance cycle ends, and never when no read is pending.
- Each descriptor's end pointer is not below its buffer position.
- `kick` is a single-cycle pulse.

The bench memory model answers each accepted read on the following cycle and never otherwise. It applies periodic stalls to `mem_req_ready` and `out_ready` so that hold behaviour is exercised. Every descriptor it builds has an end pointer at or above its start. The kick that must be ignored is also a single-cycle pulse.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 4;
  // flag word bit positions
  localparam int F_EOL    = 0;
  localparam int F_EOP    = 3;
  localparam int F_IRQ    = 4;
  localparam int F_MD_LSB = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_DREQ, S_DRSP, S_CALC, S_META, S_WREQ, S_WRSP,
    S_PUSH, S_WB, S_FIN, S_CREQ, S_CRSP, S_CWR
  } dtx_state_t;

  // bytes to move in the next pass, bounded by the chunk cap
  function automatic logic [31:0] chunk_len(input logic [31:0] end_ptr,
                                            input logic [31:0] cur,
                                            input logic [31:0] cap);
    logic [31:0] left;
    left = end_ptr - cur;
    return (left > cap) ? cap : left;
  endfunction

  // little-endian byte lane pick
  function automatic logic [7:0] lane_byte(input logic [31:0] w,
                                           input logic [1:0]  lane);
    return 8'(w >> {lane, 3'b000});
  endfunction
endpackage

// File: rtl/dtx_desc_store.sv
module dtx_desc_store #(
  parameter int NWORDS = 4,
  parameter int WW     = 32,
  localparam int IW    = $clog2(NWORDS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cap_en,
  input  logic [IW-1:0]              cap_idx,
  input  logic [WW-1:0]              cap_word,
  input  logic [IW-1:0]              rd_idx,
  output logic [WW-1:0]              rd_word,
  output logic [NWORDS-1:0][WW-1:0]  words
);
  logic [WW-1:0] slot [NWORDS];

  for (genvar g = 0; g < NWORDS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot[g] <= '0;
      else if (cap_en && cap_idx == IW'(g))
        slot[g] <= cap_word;
    end
    assign words[g] = slot[g];
  end

  assign rd_word = slot[rd_idx];
endmodule

// File: rtl/dtx_byte_lane.sv
module dtx_byte_lane
  import dtx_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        lane,
  output logic [7:0]        byte_out
);
  assign byte_out = lane_byte(word, lane);
endmodule

// File: rtl/chain_tx_dma.sv
module chain_tx_dma
  import dtx_pkg::*;
#(
  parameter int CHUNK_BYTES  = 2048,
  parameter int CTX_FLAG_OFS = 4,
  parameter int CTX_DIS_BIT  = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        kick,
  input  logic [31:0] kick_desc_addr,
  input  logic [31:0] kick_ctx_addr,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_write,
  output logic [31:0] mem_req_addr,
  output logic [31:0] mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_last,
  output logic        meta_valid,
  output logic [15:0] meta_data,
  output logic        done_irq,
  output logic        eol_flag,
  output logic        busy,
  output logic [31:0] cur_desc_addr,
  output logic [31:0] cur_buf_pos
);
  localparam int          LEN_W = $clog2(CHUNK_BYTES + 1);
  localparam logic [31:0] CAP   = 32'(CHUNK_BYTES);
  localparam int          IW    = $clog2(DESC_WORDS);

  dtx_state_t               st;
  logic [IW-1:0]            widx;
  logic [31:0]              desc_q, ctx_q, pos_q, word_q, ctxw_q;
  logic [LEN_W-1:0]         rem_q;
  logic                     meta_pend_q, load_buf_q, eol_q;
  logic [DESC_WORDS-1:0][WORD_W-1:0] dw;
  logic [WORD_W-1:0]        wb_word;

  // named events and fields for the checker
  logic [31:0] desc_next, desc_buf, desc_flags, desc_end, chunk_now;
  logic        desc_eop, byte_take, chunk_last, reach_end, req_take, cap_take;
  logic        unused_flag_bits;

  assign desc_next  = dw[0];
  assign desc_buf   = dw[1];
  assign desc_flags = dw[2];
  assign desc_end   = dw[3];
  assign desc_eop   = desc_flags[F_EOP];
  assign unused_flag_bits = ^{desc_flags[15:5], desc_flags[2:1]};

  assign chunk_now  = chunk_len(desc_end, pos_q, CAP);
  assign byte_take  = out_valid && out_ready;
  assign chunk_last = (rem_q == LEN_W'(1));
  assign reach_end  = ((pos_q + 32'd1) == desc_end);
  assign req_take   = mem_req_valid && mem_req_ready;
  assign cap_take   = (st == S_DRSP) && mem_rsp_valid;

  dtx_desc_store #(.NWORDS(DESC_WORDS), .WW(WORD_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_take),
    .cap_idx  (widx),
    .cap_word (mem_rsp_data),
    .rd_idx   (widx),
    .rd_word  (wb_word),
    .words    (dw)
  );

  dtx_byte_lane u_lane (
    .word     (word_q),
    .lane     (pos_q[1:0]),
    .byte_out (out_data)
  );

  // memory port
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = '0;
    mem_req_wdata = '0;
    unique case (st)
      S_DREQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = desc_q + 32'({widx, 2'b00});
      end
      S_WREQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = {pos_q[31:2], 2'b00};
      end
      S_WB: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = desc_q + 32'({widx, 2'b00});
        mem_req_wdata = wb_word;
      end
      S_CREQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = ctx_q + 32'(CTX_FLAG_OFS);
      end
      S_CWR: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = ctx_q + 32'(CTX_FLAG_OFS);
        mem_req_wdata = ctxw_q;
      end
      default: ;
    endcase
  end

  assign out_valid     = (st == S_PUSH);
  assign out_last      = chunk_last && reach_end && desc_eop;
  assign meta_valid    = (st == S_META) && meta_pend_q;
  assign meta_data     = desc_flags[F_MD_LSB +: 16];
  assign done_irq      = (st == S_FIN) && desc_flags[F_IRQ];
  assign busy          = (st != S_IDLE);
  assign eol_flag      = eol_q;
  assign cur_desc_addr = desc_q;
  assign cur_buf_pos   = pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      widx        <= '0;
      desc_q      <= '0;
      ctx_q       <= '0;
      pos_q       <= '0;
      word_q      <= '0;
      ctxw_q      <= '0;
      rem_q       <= '0;
      meta_pend_q <= 1'b0;
      load_buf_q  <= 1'b0;
      eol_q       <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (kick) begin
          desc_q      <= kick_desc_addr;
          ctx_q       <= kick_ctx_addr;
          eol_q       <= 1'b0;
          meta_pend_q <= 1'b1;
          load_buf_q  <= 1'b1;
          widx        <= '0;
          st          <= S_DREQ;
        end
        S_DREQ: if (mem_req_ready) st <= S_DRSP;
        S_DRSP: if (mem_rsp_valid) begin
          if (widx == IW'(DESC_WORDS - 1)) begin
            widx <= '0;
            st   <= S_CALC;
          end else begin
            widx <= widx + IW'(1);
            st   <= S_DREQ;
          end
        end
        S_CALC: begin
          if (load_buf_q) begin
            pos_q      <= desc_buf;
            load_buf_q <= 1'b0;
          end
          st <= S_META;
        end
        S_META: begin
          meta_pend_q <= 1'b0;
          rem_q       <= chunk_now[LEN_W-1:0];
          widx        <= '0;
          st          <= (chunk_now == 32'd0) ? S_WB : S_WREQ;
        end
        S_WREQ: if (mem_req_ready) st <= S_WRSP;
        S_WRSP: if (mem_rsp_valid) begin
          word_q <= mem_rsp_data;
          st     <= S_PUSH;
        end
        S_PUSH: if (byte_take) begin
          pos_q <= pos_q + 32'd1;
          rem_q <= rem_q - LEN_W'(1);
          if (chunk_last) begin
            widx <= '0;
            st   <= reach_end ? S_WB : S_DREQ;
          end else if (pos_q[1:0] == 2'b11) begin
            st <= S_WREQ;
          end
        end
        S_WB: if (mem_req_ready) begin
          if (widx == IW'(DESC_WORDS - 1)) begin
            widx <= '0;
            st   <= S_FIN;
          end else begin
            widx <= widx + IW'(1);
          end
        end
        S_FIN: begin
          if (desc_eop) meta_pend_q <= 1'b1;
          if (desc_flags[F_EOL]) begin
            st <= S_CREQ;
          end else begin
            desc_q     <= desc_next;
            load_buf_q <= 1'b1;
            st         <= S_DREQ;
          end
        end
        S_CREQ: if (mem_req_ready) st <= S_CRSP;
        S_CRSP: if (mem_rsp_valid) begin
          ctxw_q <= mem_rsp_data | (32'd1 << CTX_DIS_BIT);
          st     <= S_CWR;
        end
        S_CWR: if (mem_req_ready) begin
          eol_q <= 1'b1;
          st    <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dtx_chk.sv
module dtx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_data,
  input logic        out_last,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_write,
  input logic [31:0] mem_req_addr,
  input logic        meta_valid,
  input logic        done_irq,
  input logic        eol_flag,
  input logic        busy,
  input logic [31:0] cur_buf_pos,
  input logic        eop_bit,
  input logic [31:0] end_ptr
);
  // R2: a stalled memory request holds its address and direction
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

  // R3: a stalled stream byte stays put
  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last) && $stable(cur_buf_pos));

  // R4: no byte is offered at or past the end pointer
  p_no_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> cur_buf_pos != end_ptr);

  // R5: packet end only on the final byte of a packet-end descriptor
  p_last_rule_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> eop_bit && (cur_buf_pos + 32'd1 == end_ptr));

  // R6: metadata is a single-cycle pulse
  p_meta_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    meta_valid |=> !meta_valid);

  // R7: interrupt is a single-cycle pulse
  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  // R12: the end-of-list state is quiet
  p_eol_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    eol_flag |-> !mem_req_valid && !out_valid && !meta_valid);

  // R12: a new run always leaves the end-of-list state
  p_fresh_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !eol_flag);
endmodule

bind chain_tx_dma dtx_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_data      (out_data),
  .out_last      (out_last),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .meta_valid    (meta_valid),
  .done_irq      (done_irq),
  .eol_flag      (eol_flag),
  .busy          (busy),
  .cur_buf_pos   (cur_buf_pos),
  .eop_bit       (desc_eop),
  .end_ptr       (desc_end)
);

// File: tb/sim_chain_tx_dma.sv
`timescale 1ns/1ps
module sim_chain_tx_dma;
  localparam int CHUNK = 16;
  // {start offset, length, flags[7:0]}
  localparam logic [23:0] VEC [6] = '{
    24'h00_08_19, 24'h01_05_01, 24'h03_01_09,
    24'h02_00_11, 24'h00_10_09, 24'h05_28_19
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        kick = 1'b0;
  logic [31:0] kick_desc_addr = '0, kick_ctx_addr = '0;
  logic        mem_req_valid, mem_req_write, mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        out_valid, out_last, out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        meta_valid, done_irq, eol_flag, busy;
  logic [15:0] meta_data;
  logic [31:0] cur_desc_addr, cur_buf_pos;

  always #4 clk = ~clk;

  chain_tx_dma #(.CHUNK_BYTES(CHUNK)) u0 (.*);

  logic [31:0] mem [1024];
  int wr_cnt [1024];
  int rd_cnt [1024];
  logic [7:0] got_b [256];
  logic       got_l [256];
  logic [15:0] meta_v [8];
  int got_n, meta_n, irq_n, acc_n, cyc;
  int n_chk = 0, n_err = 0;
  bit stall = 1'b0;
  bit pend = 1'b0;
  logic [31:0] pend_a;

  // memory and sink model, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = 1'b0;
    if (!rst_n) begin
      pend = 1'b0;
      mem_req_ready = 1'b0;
      out_ready = 1'b0;
    end else begin
      if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem[pend_a[11:2]];
        pend = 1'b0;
      end
      mem_req_ready = stall ? (cyc % 3 != 1) : 1'b1;
      out_ready     = stall ? (cyc % 4 != 2) : 1'b1;
      if (mem_req_valid && mem_req_ready) begin
        acc_n++;
        if (mem_req_write) begin
          mem[mem_req_addr[11:2]] = mem_req_wdata;
          wr_cnt[mem_req_addr[11:2]]++;
        end else begin
          pend = 1'b1;
          pend_a = mem_req_addr;
          rd_cnt[mem_req_addr[11:2]]++;
        end
      end
      if (out_valid && out_ready && got_n < 256) begin
        got_b[got_n] = out_data;
        got_l[got_n] = out_last;
        got_n++;
      end
      if (meta_valid) begin
        if (meta_n < 8) meta_v[meta_n] = meta_data;
        meta_n++;
      end
      if (done_irq) irq_n++;
    end
  end

  function automatic logic [7:0] mb(input logic [31:0] a);
    return 8'(mem[a[11:2]] >> {a[1:0], 3'b000});
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic fill_mem();
    for (int k = 0; k < 1024; k++) begin
      mem[k] = (32'(k) * 32'h0103_0507) ^ 32'hA5C3_1E0F;
      wr_cnt[k] = 0;
      rd_cnt[k] = 0;
    end
  endtask

  task automatic clear_logs();
    for (int k = 0; k < 1024; k++) begin
      wr_cnt[k] = 0;
      rd_cnt[k] = 0;
    end
    got_n = 0; meta_n = 0; irq_n = 0; acc_n = 0;
  endtask

  task automatic put_desc(input logic [31:0] d, nx, bf, fl, af);
    mem[d[11:2]]      = nx;
    mem[d[11:2] + 1]  = bf;
    mem[d[11:2] + 2]  = fl;
    mem[d[11:2] + 3]  = af;
  endtask

  task automatic fire(input logic [31:0] d, input logic [31:0] c);
    @(negedge clk);
    kick = 1'b1; kick_desc_addr = d; kick_ctx_addr = c;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic wait_idle();
    int t;
    t = 0;
    while (busy && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(!busy, "R12 run ends", 32'(busy), 32'd0);
  endtask

  task automatic cmp_bytes(input logic [31:0] base, input int n, input int from, input string rq);
    int bad;
    bad = 0;
    for (int k = 0; k < n; k++)
      if (got_b[from + k] !== mb(base + 32'(k))) bad++;
    chk(bad == 0, rq, 32'(bad), 32'd0);
  endtask

  task automatic run_vec(input int i);
    logic [7:0] off, len, fl;
    logic [31:0] bufa, aft, flw;
    logic [15:0] md;
    int nlast, fetches;
    off = VEC[i][23:16]; len = VEC[i][15:8]; fl = VEC[i][7:0];
    bufa = 32'h200 + 32'(off);
    aft  = bufa + 32'(len);
    md   = 16'hA500 + 16'(i);
    flw  = {md, 8'h00, fl};
    put_desc(32'h100, 32'h1F0, bufa, flw, aft);
    mem[32'h84 >> 2] = 32'h0000_0081;
    clear_logs();
    stall = i[0];
    fire(32'h100, 32'h80);
    wait_idle();
    chk(got_n == int'(len), (len == 0) ? "R11 no bytes" : "R3 byte count", 32'(got_n), 32'(len));
    cmp_bytes(bufa, int'(len), 0, "R3 byte values");
    nlast = 0;
    for (int k = 0; k < got_n; k++) if (got_l[k]) nlast++;
    chk(nlast == int'(fl[3] && len != 0), "R5 last count", 32'(nlast), 32'(fl[3] && len != 0));
    if (fl[3] && len != 0) chk(got_l[len - 1] == 1'b1, "R5 last position", 32'(got_l[len - 1]), 32'd1);
    chk(meta_n == 1, "R6 meta count", 32'(meta_n), 32'd1);
    chk(meta_v[0] == md, "R6 meta value", 32'(meta_v[0]), 32'(md));
    chk(irq_n == int'(fl[4]), "R7 irq count", 32'(irq_n), 32'(fl[4]));
    fetches = (len == 0) ? 1 : (int'(len) + CHUNK - 1) / CHUNK;
    chk(rd_cnt[32'h100 >> 2] == fetches, "R4 descriptor fetches", 32'(rd_cnt[32'h100 >> 2]), 32'(fetches));
    chk(rd_cnt[32'h10C >> 2] == fetches, "R2 end word read", 32'(rd_cnt[32'h10C >> 2]), 32'(fetches));
    for (int w = 0; w < 4; w++)
      chk(wr_cnt[(32'h100 >> 2) + w] == 1, "R8 writeback count", 32'(wr_cnt[(32'h100 >> 2) + w]), 32'd1);
    chk(mem[32'h108 >> 2] == flw, "R8 writeback value", mem[32'h108 >> 2], flw);
    chk(mem[32'h84 >> 2] == 32'h0000_8081, "R10 context disable", mem[32'h84 >> 2], 32'h0000_8081);
    chk(eol_flag == 1'b1, "R10 eol flag", 32'(eol_flag), 32'd1);
    chk(cur_buf_pos == aft, "R13 final position", cur_buf_pos, aft);
    chk(cur_desc_addr == 32'h100, "R13 final descriptor", cur_desc_addr, 32'h100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int snap_acc, snap_got;
    fill_mem();
    clear_logs();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !eol_flag && !out_valid && !mem_req_valid && !meta_valid && !done_irq,
        "R1 reset outputs", {26'd0, busy, eol_flag, out_valid, mem_req_valid, meta_valid, done_irq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) run_vec(i);

    // R1 reset in the middle of a transfer
    put_desc(32'h100, 32'h1F0, 32'h205, {16'h0, 8'h0, 8'h09}, 32'h22D);
    clear_logs();
    stall = 1'b1;
    fire(32'h100, 32'h80);
    while (got_n < 3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(!busy && !eol_flag && !out_valid && !mem_req_valid && !meta_valid,
        "R1 mid-run reset", {27'd0, busy, eol_flag, out_valid, mem_req_valid, meta_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 chain with zero-length middle descriptor, R6 metadata rule, R12 ignored kick
    put_desc(32'h140, 32'h160, 32'h300, {16'h1111, 8'h00, 8'h08}, 32'h306);
    put_desc(32'h160, 32'h180, 32'h320, {16'h2222, 8'h00, 8'h10}, 32'h320);
    put_desc(32'h180, 32'h1F0, 32'h341, {16'h3333, 8'h00, 8'h09}, 32'h348);
    mem[32'h84 >> 2] = 32'h0000_0001;
    clear_logs();
    stall = 1'b1;
    fire(32'h140, 32'h80);
    repeat (10) @(negedge clk);
    fire(32'h100, 32'h80);
    wait_idle();
    chk(got_n == 13, "R9 chained byte count", 32'(got_n), 32'd13);
    cmp_bytes(32'h300, 6, 0, "R9 first buffer bytes");
    cmp_bytes(32'h341, 7, 6, "R9 third buffer bytes");
    chk(got_l[5] && got_l[12], "R5 last per packet", {30'd0, got_l[5], got_l[12]}, 32'd3);
    chk(meta_n == 2, "R6 meta only per packet", 32'(meta_n), 32'd2);
    chk(meta_v[0] == 16'h1111, "R6 first meta", 32'(meta_v[0]), 32'h1111);
    chk(meta_v[1] == 16'h2222, "R6 meta after packet end", 32'(meta_v[1]), 32'h2222);
    chk(irq_n == 1, "R7 irq from zero-length descriptor", 32'(irq_n), 32'd1);
    chk(wr_cnt[32'h160 >> 2] == 1, "R11 zero-length writeback", 32'(wr_cnt[32'h160 >> 2]), 32'd1);
    chk(rd_cnt[32'h100 >> 2] == 0, "R12 busy kick ignored", 32'(rd_cnt[32'h100 >> 2]), 32'd0);
    chk(cur_desc_addr == 32'h180, "R13 last descriptor", cur_desc_addr, 32'h180);
    chk(cur_buf_pos == 32'h348, "R13 last position", cur_buf_pos, 32'h348);
    chk(mem[32'h84 >> 2] == 32'h0000_8001, "R10 context disable", mem[32'h84 >> 2], 32'h0000_8001);

    // R12 quiet while at end of list
    snap_acc = acc_n;
    snap_got = got_n;
    repeat (30) @(negedge clk);
    chk(acc_n == snap_acc && got_n == snap_got && eol_flag, "R12 idle at end of list",
        32'(acc_n - snap_acc), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule